// File: doc/BRIEF.md
# DAC Bit-Error Superposition Checker

This block judges whether the worst-case integral linearity error of an n-bit converter can be predicted from n single-bit measurements instead of a sweep over all 2^n codes. A measurement engine, outside this block, applies each code that has exactly one input bit set, with the converter's offset and gain already nulled. It then delivers the signed output error for that code, one error per beat, on a valid/ready stream. The beat carries the bit index, a start marker and a last marker.

Once offset and gain are nulled, the errors at the all-zeros and all-ones codes are zero, so the single-bit errors should cancel. The block keeps a running total of the positive errors and a separate running total of the negative ones. Their algebraic sum is the superposition error. Half the sum of the error magnitudes is the predicted maximum linearity error. When superposition holds, that maximum appears at one code and, with opposite sign, at its one's complement. The block reports as the worst code the pattern whose set bits are the bits with a positive error. A pass flag tells the user whether the imbalance is small enough for the prediction to be trusted. When it is not, a full-code test is needed.

Errors are signed two's-complement numbers in units of 1/1000 LSB, 24 bits by default. The trust threshold defaults to 100 units, which is one tenth of an LSB. Input back-pressure: the engine may hold `in_valid` high for as long as it likes, and a beat is taken only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly when a result is held and the consumer is not taking it. The result side follows the same rule: a result stays on the outputs unchanged until an edge where `res_valid` and `res_ready` are both high.

Top module: `superposition_checker`

## Requirements
- R1: After reset, `res_valid` is 0, `in_ready` is 1, and the result outputs `res_pos`, `res_neg`, `res_diff`, `res_max` and `res_code` are all zero.
- R2: `res_pos` equals the sum of the strictly positive errors taken since the most recent beat with `in_start` set, including that beat and the beat marked last.
- R3: `res_neg` equals the sum of the strictly negative errors taken over the same span, so it is zero or negative.
- R4: `res_diff` equals `res_pos + res_neg`, which is the superposition error.
- R5: `res_max` equals `(res_pos - res_neg)` shifted right by one, rounded toward zero. This is half the sum of the error magnitudes.
- R6: `res_pass` is 1 exactly when `|res_diff|` is at most THRESH. At the default threshold, a difference of +100 or -100 passes, and +101 or -101 fails.
- R7: Bit i of `res_code` (bit 0 = converter LSB index 0) is 1 exactly when the error most recently taken for index i in the current frame is greater than zero. It is 0 for indices that were not delivered in that frame.
- R8: `res_valid` goes to 1 on the clock edge after the one that takes a beat with `in_last` set, and it stays 0 while a frame is still open.
- R9: While `res_valid` is 1 and `res_ready` is 0, `in_ready` is 0 and every result output holds its value. A cycle with `res_ready` high releases the result.
- R10: A beat with `in_start` set discards any partial frame. Only that beat and the ones after it count toward the next result.
- R11: A cycle with `in_valid` low changes nothing, whatever `in_idx` and `in_err` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Error beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_start | input | 1 | Beat opens a new frame |
| in_last | input | 1 | Beat closes the frame |
| in_idx | input | IDX_W | Converter bit index of this error |
| in_err | input | ERR_W | Signed error, 1/1000 LSB units |
| res_valid | output | 1 | Result held on the outputs |
| res_ready | input | 1 | Consumer takes the result |
| res_pos | output | SUM_W | Sum of positive errors |
| res_neg | output | SUM_W | Sum of negative errors |
| res_diff | output | SUM_W | Superposition error (algebraic sum) |
| res_max | output | SUM_W | Predicted worst-case linearity error |
| res_pass | output | 1 | Superposition error within threshold |
| res_code | output | NBITS | Worst-case code (bits with positive error) |

## Verification
The result handshake and the opening of the next frame can fall on the same clock edge. The consumer raises `res_ready` in the same cycle that the engine presents a start beat, so the old result is released and the new frame's first error is accumulated on a single edge. This is provoked on every frame of the sweep over 4-bit error sets, after the result has been held for zero, one or two cycles. It is judged by checking that the following result contains no trace of the earlier frame, and that `res_valid` is low until that frame's last beat.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned SP_DEF_BITS   = 12;
  localparam int unsigned SP_DEF_ERR_W  = 24;
  localparam int unsigned SP_DEF_THRESH = 100;

  // Accumulator action chosen per cycle by the stream front end
  typedef enum logic [1:0] {
    ACC_HOLD    = 2'd0,
    ACC_ADD     = 2'd1,
    ACC_RESTART = 2'd2
  } acc_op_e;
endpackage

// File: rtl/sp_accum.sv
module sp_accum
  import sp_pkg::*;
#(
  parameter int unsigned NBITS = SP_DEF_BITS,
  parameter int unsigned ERR_W = SP_DEF_ERR_W,
  parameter int unsigned SUM_W = ERR_W + 5,
  parameter int unsigned IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  acc_op_e                 op,
  input  logic [IDX_W-1:0]        idx,
  input  logic [ERR_W-1:0]        err,
  output logic signed [SUM_W-1:0] pos_q,
  output logic signed [SUM_W-1:0] neg_q,
  output logic [NBITS-1:0]        code_q,
  output logic signed [SUM_W-1:0] pos_nx,
  output logic signed [SUM_W-1:0] neg_nx,
  output logic [NBITS-1:0]        code_nx
);
  localparam int unsigned EXT_W = SUM_W - ERR_W;

  logic signed [SUM_W-1:0] err_x;
  logic signed [SUM_W-1:0] pos_base, neg_base;
  logic                    err_is_pos, err_is_neg;

  assign err_x      = {{EXT_W{err[ERR_W-1]}}, err};
  assign err_is_neg = err[ERR_W-1];
  assign err_is_pos = !err[ERR_W-1] && (|err);

  assign pos_base = (op == ACC_RESTART) ? '0 : pos_q;
  assign neg_base = (op == ACC_RESTART) ? '0 : neg_q;

  always_comb begin
    pos_nx = pos_q;
    neg_nx = neg_q;
    if (op != ACC_HOLD) begin
      pos_nx = err_is_pos ? pos_base + err_x : pos_base;
      neg_nx = err_is_neg ? neg_base + err_x : neg_base;
    end
  end

  // One mask bit per converter bit: set when the latest error for it is positive
  for (genvar gi = 0; gi < NBITS; gi++) begin : g_mask
    logic hit;
    assign hit = (op != ACC_HOLD) && (idx == IDX_W'(gi));
    always_comb begin
      if (hit)                    code_nx[gi] = err_is_pos;
      else if (op == ACC_RESTART) code_nx[gi] = 1'b0;
      else                        code_nx[gi] = code_q[gi];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      neg_q  <= '0;
      code_q <= '0;
    end else begin
      pos_q  <= pos_nx;
      neg_q  <= neg_nx;
      code_q <= code_nx;
    end
  end

  // R2
  pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n) pos_q >= 0);
  // R3
  neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n) neg_q <= 0);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == ACC_HOLD) |=> ($stable(pos_q) && $stable(neg_q) && $stable(code_q)));
endmodule

// File: rtl/sp_judge.sv
module sp_judge #(
  parameter int unsigned SUM_W  = 29,
  parameter int unsigned THRESH = 100
) (
  input  logic signed [SUM_W-1:0] pos,
  input  logic signed [SUM_W-1:0] neg,
  output logic signed [SUM_W-1:0] diff,
  output logic signed [SUM_W-1:0] max_err,
  output logic                    pass
);
  localparam logic [SUM_W-1:0] TH_V = SUM_W'(THRESH);

  logic signed [SUM_W-1:0] mag_sum;
  logic        [SUM_W-1:0] abs_diff;

  assign diff     = pos + neg;
  assign mag_sum  = pos - neg;
  assign max_err  = mag_sum >>> 1;
  assign abs_diff = diff[SUM_W-1] ? SUM_W'(-diff) : SUM_W'(diff);
  assign pass     = (abs_diff <= TH_V);
endmodule

// File: rtl/superposition_checker.sv
module superposition_checker
  import sp_pkg::*;
#(
  parameter int unsigned NBITS  = SP_DEF_BITS,
  parameter int unsigned ERR_W  = SP_DEF_ERR_W,
  parameter int unsigned THRESH = SP_DEF_THRESH,
  localparam int unsigned IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1,
  localparam int unsigned SUM_W = ERR_W + IDX_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_start,
  input  logic                    in_last,
  input  logic [IDX_W-1:0]        in_idx,
  input  logic [ERR_W-1:0]        in_err,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic signed [SUM_W-1:0] res_pos,
  output logic signed [SUM_W-1:0] res_neg,
  output logic signed [SUM_W-1:0] res_diff,
  output logic signed [SUM_W-1:0] res_max,
  output logic                    res_pass,
  output logic [NBITS-1:0]        res_code
);
  localparam logic signed [SUM_W-1:0] TH_P = SUM_W'(THRESH);
  localparam logic signed [SUM_W-1:0] TH_N = -TH_P;

  logic                    take;
  acc_op_e                 op;
  logic signed [SUM_W-1:0] pos_q, neg_q, pos_nx, neg_nx;
  logic [NBITS-1:0]        code_q, code_nx;
  logic signed [SUM_W-1:0] j_diff, j_max;
  logic                    j_pass;

  assign in_ready = !res_valid || res_ready;
  assign take     = in_valid && in_ready;
  assign op       = !take ? ACC_HOLD : (in_start ? ACC_RESTART : ACC_ADD);

  sp_accum #(
    .NBITS(NBITS), .ERR_W(ERR_W), .SUM_W(SUM_W), .IDX_W(IDX_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .op(op), .idx(in_idx), .err(in_err),
    .pos_q(pos_q), .neg_q(neg_q), .code_q(code_q),
    .pos_nx(pos_nx), .neg_nx(neg_nx), .code_nx(code_nx)
  );

  sp_judge #(.SUM_W(SUM_W), .THRESH(THRESH)) u_judge (
    .pos(pos_nx), .neg(neg_nx),
    .diff(j_diff), .max_err(j_max), .pass(j_pass)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_pos   <= '0;
      res_neg   <= '0;
      res_diff  <= '0;
      res_max   <= '0;
      res_pass  <= 1'b0;
      res_code  <= '0;
    end else if (take && in_last) begin
      res_valid <= 1'b1;
      res_pos   <= pos_nx;
      res_neg   <= neg_nx;
      res_diff  <= j_diff;
      res_max   <= j_max;
      res_pass  <= j_pass;
      res_code  <= code_nx;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R8
  last_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_last) |=> res_valid);
  // R9
  held_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_diff) &&
                                   $stable(res_code) && $stable(res_pass)));
  // R6
  pass_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pass) |-> (res_diff <= TH_P && res_diff >= TH_N));
  // R5
  max_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_max >= 0));
endmodule

// File: tb/superposition_checker_tb.sv
module superposition_checker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int EW = 24;
  localparam int TH = 100;
  localparam int IW = 2;
  localparam int SW = EW + IW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0, res_ready = 1'b0;
  logic [IW-1:0] in_idx = '0;
  logic [EW-1:0] in_err = '0;
  logic in_ready, res_valid, res_pass;
  logic signed [SW-1:0] res_pos, res_neg, res_diff, res_max;
  logic [NB-1:0] res_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  superposition_checker #(.NBITS(NB), .ERR_W(EW), .THRESH(TH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_last(in_last), .in_idx(in_idx), .in_err(in_err),
    .res_valid(res_valid), .res_ready(res_ready), .res_pos(res_pos),
    .res_neg(res_neg), .res_diff(res_diff), .res_max(res_max),
    .res_pass(res_pass), .res_code(res_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_beat(input bit st, input bit ls, input int idx, input int err);
    in_valid = 1'b1; in_start = st; in_last = ls;
    in_idx = IW'(idx); in_err = EW'(err);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_frame(input int e [NB], input int hold, input bit gap, input bit rev);
    int ep = 0, en = 0, ed, emx, ecode = 0;
    bit epass;
    for (int i = 0; i < NB; i++) begin
      if (e[i] > 0) begin ep += e[i]; ecode |= (1 << i); end
      if (e[i] < 0) en += e[i];
    end
    ed = ep + en;
    emx = (ep - en) / 2;
    epass = (ed <= TH) && (ed >= -TH);
    res_ready = 1'b1;  // release old result on the same edge as the start beat
    for (int k = 0; k < NB; k++) begin
      int i = rev ? NB - 1 - k : k;
      if (k == NB - 1) chk("R8 valid low while open", int'(res_valid), 0);
      send_beat(k == 0, k == NB - 1, i, e[i]);
      if (k == 0) res_ready = 1'b0;
      if (gap && k == 1) begin
        // R11: junk on the data lines with in_valid low
        in_idx = IW'(i); in_err = EW'(12345);
        @(negedge clk);
      end
    end
    chk("R8 valid after last", int'(res_valid), 1);
    chk("R2 pos sum", int'(res_pos), ep);
    chk("R3 neg sum", int'(res_neg), en);
    chk("R4 diff", int'(res_diff), ed);
    chk("R5 max", int'(res_max), emx);
    chk("R6 pass", int'(res_pass), int'(epass));
    chk("R7 code", int'(res_code), ecode);
    if (gap) chk("R11 idle cycle ignored", int'(res_pos) + int'(res_neg), ed);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R9 in_ready low while held", int'(in_ready), 0);
      chk("R9 diff held", int'(res_diff), ed);
      chk("R9 code held", int'(res_code), ecode);
    end
  endtask

  initial begin
    int vals [5] = '{-120, -50, 0, 30, 101};
    int e [NB];
    int n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", int'(res_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 pos", int'(res_pos), 0);
    chk("R1 diff", int'(res_diff), 0);
    chk("R1 code", int'(res_code), 0);

    // R10: partial frame abandoned by a new start
    send_beat(1, 0, 0, 700);
    send_beat(0, 0, 1, -900);
    e = '{5, -7, 0, 40};
    run_frame(e, 1, 0, 0);

    // R6 boundaries
    e = '{100, 0, 0, 0};   run_frame(e, 0, 0, 0);
    e = '{101, 0, 0, 0};   run_frame(e, 0, 0, 1);
    e = '{0, 0, -100, 0};  run_frame(e, 1, 0, 0);
    e = '{0, -151, 50, 0}; run_frame(e, 0, 1, 0);

    // Sweep of all error sets from the value list
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++)
          for (int d = 0; d < 5; d++) begin
            e = '{vals[a], vals[b], vals[c], vals[d]};
            run_frame(e, n % 3, (n % 4) == 1, (n % 2) == 1);
            n++;
          end

    res_ready = 1'b1;
    @(negedge clk);
    chk("R9 released", int'(res_valid), 0);
    chk("R9 in_ready after release", int'(in_ready), 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule